// File: doc/BRIEF.md
# Peripheral Power Mode Controller

This block sequences a peripheral subsystem through four power states: full power, doze, nap and sleep. Software sets the power-management enable bit and picks a target mode. The block then grants the low-power state and gates the enables of the individual functional units. Doze may be entered whatever the processor core is doing. Nap and sleep are granted only while the core is in a low-power state or has asked for one. While the core is held quiet, the block raises a quiesce acknowledge towards it.

A low-power state is left on a wake event. The events are a PCI access that targets system memory, a processor bus request, an NMI that is qualified by the machine-check enable, and a synchronous hard reset. Most wakes are permanent. The block asks for the enable bit to be cleared, then restores the units over a fixed recovery window before it reports full power. A PCI access that arrives during nap is handled differently. The block enables the units for the transfer and keeps the acknowledge high, so the core stays asleep. When the transfer-done strobe arrives, it drops back into nap by itself. The PLL, the memory controller and the PCI datapath sit outside this block; they appear here only as strobes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While rst_ni is low, and on the clock edge after hard_rst_i is sampled high in any state, state_o is 0 (full power) and quiesce_ack_o is 0. A sampled hard_rst_i also sets pm_clr_o for the following cycle, and it overrides every other input.
- R2: From full power, with pm_en_i high, mode_sel_i 01 enters doze (state_o 1) on the next edge whatever core_lp_i is. Mode 10 enters nap (2) and mode 11 enters sleep (3), but only when core_lp_i is high. Mode 00, or pm_en_i low, leaves the block in full power.
- R3: unit_en_o bit map: 0 PCI decode, 1 arbiter, 2 RAM refresh, 3 bus-request monitor, 4 NMI monitor, 5 interrupt controller, 6 I2C, 7 other units. In doze and nap unit_en_o is 8'h7F. In full power, PCI service (state_o 4) and recovery (state_o 5) it is 8'hFF.
- R4: In sleep, unit_en_o is 8'h7A, with bit 2 (refresh) equal to lp_ref_en_i.
- R5: In nap, nmi_i wakes the block only while mce_en_i is high. A bus request or a qualified NMI moves the block to recovery on the next edge.
- R6: In nap, a PCI memory hit with no other cause present moves the block to PCI service (state_o 4). In that state quiesce_ack_o stays 1 and pm_clr_o stays 0. The edge after xact_done_i is sampled high returns the block to nap.
- R7: Every wake other than the PCI temporary wake enters recovery and pulses pm_clr_o high for exactly the first recovery cycle.
- R8: In sleep, PCI hits are ignored. bus_req_i counts as a wake only while cko_sel_i is high.
- R9: Recovery lasts WAKE_CYC cycles (default 4). Throughout it, wake_busy_o is 1, all units are enabled and the acknowledge is 0. The block then returns to full power.
- R10: Wake causes in the same cycle are ranked hard reset, then NMI, then bus request, then PCI. A PCI hit together with a qualified NMI or bus request gives a permanent wake, not PCI service.
- R11: In doze, any qualified event, a PCI hit included, gives a permanent wake with pm_clr_o. The acknowledge is 0 in doze.
- R12: quiesce_ack_o is 1 exactly in nap, sleep and PCI service.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hard_rst_i | input | 1 | Synchronous hard reset event |
| pm_en_i | input | 1 | Power-management enable bit |
| mode_sel_i | input | 2 | Target mode: 01 doze, 10 nap, 11 sleep |
| core_lp_i | input | 1 | Core is in, or requested, nap or sleep |
| mce_en_i | input | 1 | Machine-check enable qualifying NMI |
| lp_ref_en_i | input | 1 | RAM refresh enable during sleep |
| cko_sel_i | input | 1 | Qualifies bus request as a sleep wake |
| pci_mem_hit_i | input | 1 | PCI transaction targets system memory |
| bus_req_i | input | 1 | Processor bus request |
| nmi_i | input | 1 | Non-maskable interrupt |
| xact_done_i | input | 1 | PCI transaction serviced strobe |
| unit_en_o | output | 8 | Per-unit enables, bit map in R3 |
| quiesce_ack_o | output | 1 | Quiesce acknowledge to the core |
| pm_clr_o | output | 1 | Clear request for the enable bit |
| wake_busy_o | output | 1 | Recovery window in progress |
| state_o | output | 3 | 0 full, 1 doze, 2 nap, 3 sleep, 4 PCI service, 5 recovery |

## Verification
On every cycle the assertions check the fixed relations between state and outputs. These are the enable maps for doze, nap and sleep, the acknowledge held through PCI service, the clear pulse only in full power or recovery, and busy implying all units on. They also check that hard reset lands in full power, and that sleep holds when no qualified cause is present. The bench scenarios are needed for the sequences. Those are the conditional entry on core_lp_i, the exact length of the recovery window, and the round trip from nap through PCI service and back. They also cover the priority outcome when PCI coincides with NMI or a bus request, and hard reset striking in the middle of recovery or service.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [2:0] {
    ST_FULL  = 3'd0,
    ST_DOZE  = 3'd1,
    ST_NAP   = 3'd2,
    ST_SLEEP = 3'd3,
    ST_PSVC  = 3'd4,
    ST_WAKE  = 3'd5
  } pm_state_e;

  typedef enum logic [2:0] {
    WK_NONE = 3'd0,
    WK_RST  = 3'd1,
    WK_NMI  = 3'd2,
    WK_BREQ = 3'd3,
    WK_PCI  = 3'd4
  } wake_e;

  localparam int unsigned UNIT_W    = 8;
  localparam int unsigned U_PCI_DEC = 0;
  localparam int unsigned U_ARB     = 1;
  localparam int unsigned U_REFRESH = 2;
  localparam int unsigned U_BREQ    = 3;
  localparam int unsigned U_NMI     = 4;
  localparam int unsigned U_INTC    = 5;
  localparam int unsigned U_I2C     = 6;
  localparam int unsigned U_OTHER   = 7;

  localparam logic [1:0] MODE_DOZE  = 2'b01;
  localparam logic [1:0] MODE_NAP   = 2'b10;
  localparam logic [1:0] MODE_SLEEP = 2'b11;
endpackage

// File: rtl/pmc_wake_arb.sv
module pmc_wake_arb
  import pmc_pkg::*;
(
  input  pm_state_e state_i,
  input  logic      hard_rst_i,
  input  logic      nmi_i,
  input  logic      mce_en_i,
  input  logic      bus_req_i,
  input  logic      cko_sel_i,
  input  logic      pci_mem_hit_i,
  output wake_e     cause_o
);
  logic nmi_ok, breq_ok, pci_ok;

  assign nmi_ok  = nmi_i & mce_en_i;
  // sleep needs the clock-out select to honour a bus request
  assign breq_ok = bus_req_i & ((state_i != ST_SLEEP) | cko_sel_i);
  // PCI decode is off in sleep
  assign pci_ok  = pci_mem_hit_i & ((state_i == ST_DOZE) | (state_i == ST_NAP));

  always_comb begin
    if (hard_rst_i)   cause_o = WK_RST;
    else if (nmi_ok)  cause_o = WK_NMI;
    else if (breq_ok) cause_o = WK_BREQ;
    else if (pci_ok)  cause_o = WK_PCI;
    else              cause_o = WK_NONE;
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      pm_en_i,
  input  logic [1:0] mode_sel_i,
  input  logic      core_lp_i,
  input  logic      xact_done_i,
  input  wake_e     cause_i,
  output pm_state_e state_o,
  output logic      pm_clr_o
);
  localparam int unsigned CNT_W = $clog2(WAKE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WAKE_CYC - 1);

  pm_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             clr_q, clr_d;
  logic             perm_wake;

  assign perm_wake = (cause_i == WK_NMI) | (cause_i == WK_BREQ);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    clr_d   = 1'b0;
    if (cause_i == WK_RST) begin
      state_d = ST_FULL;
      clr_d   = 1'b1;
    end else begin
      unique case (state_q)
        ST_FULL: begin
          if (pm_en_i) begin
            if (mode_sel_i == MODE_DOZE)                  state_d = ST_DOZE;
            else if (mode_sel_i == MODE_NAP && core_lp_i)   state_d = ST_NAP;
            else if (mode_sel_i == MODE_SLEEP && core_lp_i) state_d = ST_SLEEP;
          end
        end
        ST_DOZE: begin
          if (cause_i != WK_NONE) begin
            state_d = ST_WAKE; cnt_d = '0; clr_d = 1'b1;
          end
        end
        ST_NAP: begin
          if (perm_wake) begin
            state_d = ST_WAKE; cnt_d = '0; clr_d = 1'b1;
          end else if (cause_i == WK_PCI) begin
            state_d = ST_PSVC;
          end
        end
        ST_SLEEP, ST_PSVC: begin
          if (perm_wake) begin
            state_d = ST_WAKE; cnt_d = '0; clr_d = 1'b1;
          end else if (state_q == ST_PSVC && xact_done_i) begin
            state_d = ST_NAP;
          end
        end
        ST_WAKE: begin
          if (cnt_q == CNT_LAST) state_d = ST_FULL;
          else                   cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = ST_FULL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FULL;
      cnt_q   <= '0;
      clr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      clr_q   <= clr_d;
    end
  end

  assign state_o  = state_q;
  assign pm_clr_o = clr_q;
endmodule

// File: rtl/pmc_unit_gate.sv
module pmc_unit_gate
  import pmc_pkg::*;
(
  input  pm_state_e         state_i,
  input  logic              lp_ref_en_i,
  output logic [UNIT_W-1:0] unit_en_o,
  output logic              quiesce_ack_o,
  output logic              wake_busy_o
);
  logic low_pwr, deep;

  assign low_pwr = (state_i == ST_DOZE) | (state_i == ST_NAP) | (state_i == ST_SLEEP);
  assign deep    = (state_i == ST_SLEEP);

  for (genvar u = 0; u < UNIT_W; u++) begin : g_unit
    if (u == U_OTHER) begin : g_other
      assign unit_en_o[u] = ~low_pwr;
    end else if (u == U_PCI_DEC) begin : g_dec
      assign unit_en_o[u] = ~deep;
    end else if (u == U_REFRESH) begin : g_ref
      assign unit_en_o[u] = ~deep | lp_ref_en_i;
    end else begin : g_keep
      assign unit_en_o[u] = 1'b1;
    end
  end

  assign quiesce_ack_o = (state_i == ST_NAP) | (state_i == ST_SLEEP) | (state_i == ST_PSVC);
  assign wake_busy_o   = (state_i == ST_WAKE);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int unsigned WAKE_CYC = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hard_rst_i,
  input  logic              pm_en_i,
  input  logic [1:0]        mode_sel_i,
  input  logic              core_lp_i,
  input  logic              mce_en_i,
  input  logic              lp_ref_en_i,
  input  logic              cko_sel_i,
  input  logic              pci_mem_hit_i,
  input  logic              bus_req_i,
  input  logic              nmi_i,
  input  logic              xact_done_i,
  output logic [UNIT_W-1:0] unit_en_o,
  output logic              quiesce_ack_o,
  output logic              pm_clr_o,
  output logic              wake_busy_o,
  output logic [2:0]        state_o
);
  pm_state_e state;
  wake_e     cause;

  pmc_wake_arb i_arb (
    .state_i       (state),
    .hard_rst_i    (hard_rst_i),
    .nmi_i         (nmi_i),
    .mce_en_i      (mce_en_i),
    .bus_req_i     (bus_req_i),
    .cko_sel_i     (cko_sel_i),
    .pci_mem_hit_i (pci_mem_hit_i),
    .cause_o       (cause)
  );

  pmc_fsm #(.WAKE_CYC(WAKE_CYC)) i_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pm_en_i     (pm_en_i),
    .mode_sel_i  (mode_sel_i),
    .core_lp_i   (core_lp_i),
    .xact_done_i (xact_done_i),
    .cause_i     (cause),
    .state_o     (state),
    .pm_clr_o    (pm_clr_o)
  );

  pmc_unit_gate i_gate (
    .state_i       (state),
    .lp_ref_en_i   (lp_ref_en_i),
    .unit_en_o     (unit_en_o),
    .quiesce_ack_o (quiesce_ack_o),
    .wake_busy_o   (wake_busy_o)
  );

  assign state_o = state;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       hard_rst_i,
  input logic       pm_en_i,
  input logic       mce_en_i,
  input logic       cko_sel_i,
  input logic       lp_ref_en_i,
  input logic       nmi_i,
  input logic       bus_req_i,
  input logic [7:0] unit_en_o,
  input logic       quiesce_ack_o,
  input logic       pm_clr_o,
  input logic       wake_busy_o,
  input logic [2:0] state_o
);
  a_r1_hard_rst: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hard_rst_i |=> (state_o == 3'd0 && !quiesce_ack_o && pm_clr_o));

  a_r2_no_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd0 && !pm_en_i) |=> state_o == 3'd0);

  a_r3_doze_nap_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd1 || state_o == 3'd2) |-> unit_en_o == 8'h7F);

  a_r4_sleep_map: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 |-> unit_en_o == {4'b0111, 1'b1, lp_ref_en_i, 2'b10});

  a_r6_psvc_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd4 |-> (quiesce_ack_o && !pm_clr_o));

  a_r7_clr_where: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pm_clr_o |-> (state_o == 3'd0 || state_o == 3'd5));

  a_r8_sleep_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd3 && !hard_rst_i && !(nmi_i && mce_en_i) && !(bus_req_i && cko_sel_i))
      |=> state_o == 3'd3);

  a_r9_busy_units: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_busy_o |-> (unit_en_o == 8'hFF && !quiesce_ack_o));

  a_r12_doze_no_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd1 |-> !quiesce_ack_o);
endmodule

bind pwr_mode_ctrl pmc_checker i_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .hard_rst_i    (hard_rst_i),
  .pm_en_i       (pm_en_i),
  .mce_en_i      (mce_en_i),
  .cko_sel_i     (cko_sel_i),
  .lp_ref_en_i   (lp_ref_en_i),
  .nmi_i         (nmi_i),
  .bus_req_i     (bus_req_i),
  .unit_en_o     (unit_en_o),
  .quiesce_ack_o (quiesce_ack_o),
  .pm_clr_o      (pm_clr_o),
  .wake_busy_o   (wake_busy_o),
  .state_o       (state_o)
);

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int W = 4;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic hard_rst_i = 0, pm_en_i = 0, core_lp_i = 0, mce_en_i = 0;
  logic lp_ref_en_i = 0, cko_sel_i = 0, pci_mem_hit_i = 0, bus_req_i = 0;
  logic nmi_i = 0, xact_done_i = 0;
  logic [1:0] mode_sel_i = 2'b00;
  logic [7:0] unit_en_o;
  logic quiesce_ack_o, pm_clr_o, wake_busy_o;
  logic [2:0] state_o;

  always #2 clk_i = ~clk_i;

  pwr_mode_ctrl #(.WAKE_CYC(W)) i_pwr_mode_ctrl (.*);

  int checks = 0, errors = 0, cycles = 0;
  string cur = "R1";

  // behavioural reference: 0 full 1 doze 2 nap 3 sleep 4 pci service 5 recovery
  int m_st = 0, m_left = 0;
  bit m_clr = 0;

  always @(posedge clk_i or negedge rst_ni) begin : model
    bit nq, bq, pq, go_wake;
    if (!rst_ni) begin
      m_st = 0; m_left = 0; m_clr = 0;
    end else begin
      nq = nmi_i && mce_en_i;
      bq = bus_req_i && (m_st != 3 || cko_sel_i);
      pq = pci_mem_hit_i && (m_st == 1 || m_st == 2);
      go_wake = 0;
      m_clr = 0;
      if (hard_rst_i) begin
        m_st = 0; m_clr = 1;
      end else if (m_st == 0) begin
        if (pm_en_i && mode_sel_i == 2'b01) m_st = 1;
        else if (pm_en_i && core_lp_i && mode_sel_i == 2'b10) m_st = 2;
        else if (pm_en_i && core_lp_i && mode_sel_i == 2'b11) m_st = 3;
      end else if (m_st == 5) begin
        if (m_left == 1) m_st = 0; else m_left--;
      end else if (nq || bq) go_wake = 1;
      else if (m_st == 1 && pq) go_wake = 1;
      else if (m_st == 2 && pq) m_st = 4;
      else if (m_st == 4 && xact_done_i) m_st = 2;
      if (go_wake) begin
        m_st = 5; m_left = W; m_clr = 1;
      end
    end
  end

  function automatic logic [7:0] exp_en();
    case (m_st)
      1, 2: return 8'h7F;
      3: return 8'h7A | (8'(lp_ref_en_i) << 2);
      default: return 8'hFF;
    endcase
  endfunction

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", cur, what, act, exp, $time);
    end
  endtask

  task automatic chk();
    cmp("state", int'(state_o), m_st);
    cmp("unit_en", int'(unit_en_o), int'(exp_en()));
    cmp("ack", int'(quiesce_ack_o), int'(m_st == 2 || m_st == 3 || m_st == 4));
    cmp("busy", int'(wake_busy_o), int'(m_st == 5));
    cmp("pm_clr", int'(pm_clr_o), int'(m_clr));
  endtask

  task automatic cyc(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i); #1; chk();
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    // R1 reset state
    #3; chk();
    cmp("R1 state_o reset", int'(state_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(2);

    // R2 no entry with mode 00, nap refused without core request
    cur = "R2"; pm_en_i = 1; mode_sel_i = 2'b00; cyc(3);
    mode_sel_i = 2'b10; core_lp_i = 0; cyc(3);
    cmp("R2 nap refused", int'(state_o), 0);
    mode_sel_i = 2'b01; cyc(1);
    cmp("R2 doze entered", int'(state_o), 1);
    cur = "R3"; pm_en_i = 0; cyc(2);

    // R11 pci wakes doze permanently; R9 recovery length
    cur = "R11"; pci_mem_hit_i = 1; cyc(1); pci_mem_hit_i = 0;
    cmp("R11 clr", int'(pm_clr_o), 1);
    cur = "R9"; cyc(W);
    cmp("R9 back to full", int'(state_o), 0);

    // R5 NMI gated by machine-check enable
    cur = "R5"; pm_en_i = 1; mode_sel_i = 2'b10; core_lp_i = 1; cyc(1);
    pm_en_i = 0; cur = "R12"; cyc(1);
    cur = "R5"; nmi_i = 1; mce_en_i = 0; cyc(3);
    cmp("R5 nmi ignored", int'(state_o), 2);
    nmi_i = 0;

    // R6 temporary PCI wake and return
    cur = "R6"; pci_mem_hit_i = 1; cyc(1); pci_mem_hit_i = 0;
    cmp("R6 service", int'(state_o), 4);
    cyc(3);
    xact_done_i = 1; cyc(1); xact_done_i = 0;
    cmp("R6 renap", int'(state_o), 2);
    cyc(1);

    // R10 PCI with qualified NMI same cycle
    cur = "R10"; pci_mem_hit_i = 1; nmi_i = 1; mce_en_i = 1; cyc(1);
    pci_mem_hit_i = 0; nmi_i = 0;
    cmp("R10 permanent", int'(state_o), 5);
    cyc(W + 1);

    // R7 bus request wakes nap
    cur = "R7"; pm_en_i = 1; mode_sel_i = 2'b10; cyc(1); pm_en_i = 0; cyc(1);
    bus_req_i = 1; cyc(1); bus_req_i = 0;
    cmp("R7 clr pulse", int'(pm_clr_o), 1);
    cyc(1);
    cmp("R7 clr one cycle", int'(pm_clr_o), 0);
    cyc(W);

    // R4 / R8 sleep
    cur = "R4"; pm_en_i = 1; mode_sel_i = 2'b11; lp_ref_en_i = 0; cyc(1); pm_en_i = 0; cyc(1);
    lp_ref_en_i = 1; #1; chk();
    cur = "R8"; pci_mem_hit_i = 1; cyc(2); pci_mem_hit_i = 0;
    bus_req_i = 1; cko_sel_i = 0; cyc(2);
    cmp("R8 breq ignored", int'(state_o), 3);
    cko_sel_i = 1; cyc(1); bus_req_i = 0; cko_sel_i = 0;
    cmp("R8 breq wakes", int'(state_o), 5);

    // R1 hard reset mid recovery
    cur = "R1"; cyc(1); hard_rst_i = 1; cyc(1); hard_rst_i = 0;
    cmp("R1 hard in wake", int'(state_o), 0);
    cyc(2);

    // R1 hard reset during PCI service, beating nmi
    pm_en_i = 1; mode_sel_i = 2'b10; cyc(1); pm_en_i = 0;
    pci_mem_hit_i = 1; cyc(1); pci_mem_hit_i = 0;
    hard_rst_i = 1; nmi_i = 1; cyc(1); hard_rst_i = 0; nmi_i = 0;
    cmp("R1 hard in service", int'(state_o), 0);
    cyc(3);

    finish_run();
  end
endmodule